// File: doc/BRIEF.md
# Dual-Path Configuration Register Access Unit

This block holds a small configuration register space that two independent command sources can read and write. One source is an in-band link command port. The other is a sideband management-bus port. Each request carries a function number, a byte offset and an access size: byte, 16-bit word or 32-bit doubleword. Data moves right-justified on the ports and maps to little-endian byte lanes inside each 32-bit register.

Sideband requests are filtered by a configured node identifier. The in-band path accepts any device number. While the debug-analyzer mode input is high, the in-band path is refused. If both ports present a request in the same cycle, the sideband request is served first. Fixed read values cover addresses outside the map: all ones for a function that is not implemented, and zeros for an offset that is not implemented or an access that would cross a register.

Top module: `cfg_access_unit`

## Requirements
- R1: Size code 0 selects a byte, 1 a 16-bit word and 2 a 32-bit doubleword. Read data is returned right-justified: the byte at the lowest address sits in bits 7:0, the next higher byte in bits 15:8, and so on.
- R2: A write updates only the bytes covered by its size and by offset bits [1:0]. All other bytes of the register keep their value.
- R3: The in-band port accepts and serves a request whatever value its device field carries.
- R4: The sideband port produces a response and performs a write only when `sb_node` equals `node_id`. Any other request is consumed silently and changes nothing.
- R5: While `lai_mode` is 1, every in-band request is answered with `lk_rsp_ok`=0 and data 0, and it writes nothing. The sideband port keeps working.
- R6: A function number of `NUM_FUNCS` or more reads as 32'hFFFFFFFF, and writes to it have no effect.
- R7: A register offset at or beyond `REGS_PER_FUNC`*4 reads as 0 and cannot be written. The same holds for size code 3, for a word at offset bits [1:0]=3 and for a doubleword whose offset bits [1:0] are not 0.
- R8: When both ports request in the same cycle, `lk_req_ready` is 0. The sideband request is served, and the held in-band request is served in the next cycle.
- R9: A response appears in the cycle after the request is accepted, and a write response carries data 0. Reads never change register contents.
- R10: After reset, every register reads 0, no response is valid and `lk_req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lai_mode | input | 1 | Debug mode; refuses in-band access |
| node_id | input | NODE_W | Node identifier for the sideband port |
| lk_req_valid | input | 1 | In-band request valid |
| lk_req_ready | output | 1 | In-band request accepted this cycle |
| lk_we | input | 1 | In-band write (1) or read (0) |
| lk_dev | input | DEV_W | In-band device number (not matched) |
| lk_func | input | FUNC_W | In-band function number |
| lk_off | input | OFF_W | In-band byte offset |
| lk_size | input | 2 | In-band access size code |
| lk_wdata | input | 32 | In-band write data, right-justified |
| lk_rsp_valid | output | 1 | In-band response valid |
| lk_rsp_ok | output | 1 | In-band access allowed (0 in debug mode) |
| lk_rsp_data | output | 32 | In-band read data |
| sb_req_valid | input | 1 | Sideband request valid (always accepted) |
| sb_we | input | 1 | Sideband write (1) or read (0) |
| sb_node | input | NODE_W | Sideband target node identifier |
| sb_func | input | FUNC_W | Sideband function number |
| sb_off | input | OFF_W | Sideband byte offset |
| sb_size | input | 2 | Sideband access size code |
| sb_wdata | input | 32 | Sideband write data, right-justified |
| sb_rsp_valid | output | 1 | Sideband response valid |
| sb_rsp_data | output | 32 | Sideband read data |

## Verification
The assertions assume that every request input is defined and held steady from one falling clock edge through the next rising edge. They also assume that `lai_mode` and `node_id` change only between requests, so that the value sampled with a request is the value that governed its response. The bench drives all inputs on the falling edge and changes the mode and node inputs only while both request valids are low. Random operations draw function numbers and offsets from a range slightly wider than the map, so that unimplemented and unlisted addresses come up often, and about one sideband request in eight carries a wrong node identifier.

// File: rtl/cfg_access_unit.sv
module cfg_access_unit #(
  parameter int FUNC_W        = 3,
  parameter int OFF_W         = 8,
  parameter int NODE_W        = 7,
  parameter int DEV_W         = 5,
  parameter int NUM_FUNCS     = 2,
  parameter int REGS_PER_FUNC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lai_mode,
  input  logic [NODE_W-1:0] node_id,
  input  logic              lk_req_valid,
  output logic              lk_req_ready,
  input  logic              lk_we,
  input  logic [DEV_W-1:0]  lk_dev,
  input  logic [FUNC_W-1:0] lk_func,
  input  logic [OFF_W-1:0]  lk_off,
  input  logic [1:0]        lk_size,
  input  logic [31:0]       lk_wdata,
  output logic              lk_rsp_valid,
  output logic              lk_rsp_ok,
  output logic [31:0]       lk_rsp_data,
  input  logic              sb_req_valid,
  input  logic              sb_we,
  input  logic [NODE_W-1:0] sb_node,
  input  logic [FUNC_W-1:0] sb_func,
  input  logic [OFF_W-1:0]  sb_off,
  input  logic [1:0]        sb_size,
  input  logic [31:0]       sb_wdata,
  output logic              sb_rsp_valid,
  output logic [31:0]       sb_rsp_data
);
  localparam int NREG  = NUM_FUNCS * REGS_PER_FUNC;
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [31:0] regs [NREG];

  logic              sb_hit, lk_go, blocked;
  logic              a_we;
  logic [FUNC_W-1:0] a_func;
  logic [OFF_W-1:0]  a_off;
  logic [1:0]        a_size, lane;
  logic [31:0]       a_wdata;

  assign sb_hit       = sb_req_valid && (sb_node == node_id);
  assign lk_req_ready = !sb_req_valid;
  assign lk_go        = lk_req_valid && !sb_req_valid;
  assign blocked      = !sb_req_valid && lai_mode;

  assign a_we    = sb_req_valid ? sb_we    : lk_we;
  assign a_func  = sb_req_valid ? sb_func  : lk_func;
  assign a_off   = sb_req_valid ? sb_off   : lk_off;
  assign a_size  = sb_req_valid ? sb_size  : lk_size;
  assign a_wdata = sb_req_valid ? sb_wdata : lk_wdata;
  assign lane    = a_off[1:0];

  logic [3:0]  be;
  logic [31:0] size_mask;
  logic        fits;
  always_comb begin
    be = 4'b0000; size_mask = '0; fits = 1'b0;
    case (a_size)
      2'd0: begin be = 4'b0001 << lane; size_mask = 32'h0000_00FF; fits = 1'b1; end
      2'd1: begin be = 4'b0011 << lane; size_mask = 32'h0000_FFFF; fits = (lane != 2'd3); end
      2'd2: begin be = 4'b1111;         size_mask = 32'hFFFF_FFFF; fits = (lane == 2'd0); end
      default: ;
    endcase
  end

  logic        func_ok, word_ok, mapped;
  logic [31:0] idx_full;
  logic [IDX_W-1:0] idx;
  assign func_ok  = 32'(a_func) < NUM_FUNCS;
  assign word_ok  = 32'(a_off[OFF_W-1:2]) < REGS_PER_FUNC;
  assign mapped   = func_ok && word_ok && fits;
  assign idx_full = 32'(a_func) * REGS_PER_FUNC + 32'(a_off[OFF_W-1:2]);
  assign idx      = mapped ? idx_full[IDX_W-1:0] : '0;

  logic [31:0] rd_val, wshift;
  assign rd_val = !func_ok ? 32'hFFFF_FFFF
                : mapped   ? ((regs[idx] >> {lane, 3'b000}) & size_mask)
                :            32'h0;
  assign wshift = a_wdata << {lane, 3'b000};

  logic wr_en;
  assign wr_en = (sb_hit || lk_go) && a_we && mapped && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) regs[idx][8*b +: 8] <= wshift[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb_rsp_valid <= 1'b0;
      sb_rsp_data  <= '0;
      lk_rsp_valid <= 1'b0;
      lk_rsp_ok    <= 1'b0;
      lk_rsp_data  <= '0;
    end else begin
      sb_rsp_valid <= sb_hit;
      lk_rsp_valid <= lk_go;
      if (sb_hit) sb_rsp_data <= a_we ? 32'h0 : rd_val;
      if (lk_go) begin
        lk_rsp_ok   <= !lai_mode;
        lk_rsp_data <= (a_we || lai_mode) ? 32'h0 : rd_val;
      end
    end
  end
endmodule

module cfg_access_chk #(
  parameter int FUNC_W    = 3,
  parameter int NODE_W    = 7,
  parameter int NUM_FUNCS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lai_mode,
  input logic [NODE_W-1:0] node_id,
  input logic              lk_req_valid,
  input logic              lk_req_ready,
  input logic              lk_rsp_valid,
  input logic              lk_rsp_ok,
  input logic [31:0]       lk_rsp_data,
  input logic              sb_req_valid,
  input logic              sb_we,
  input logic [NODE_W-1:0] sb_node,
  input logic [FUNC_W-1:0] sb_func,
  input logic              sb_rsp_valid,
  input logic [31:0]       sb_rsp_data
);
  a_r8_sb_first: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid |-> !lk_req_ready);

  a_r4_node_filter: assert property (@(posedge clk) disable iff (!rst_n)
    sb_rsp_valid |-> $past(sb_req_valid && (sb_node == node_id)));

  a_r9_lk_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid |-> $past(lk_req_valid && lk_req_ready));

  a_r5_lai_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rsp_valid && $past(lai_mode)) |-> (!lk_rsp_ok && lk_rsp_data == 32'h0));

  a_r6_unimpl_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_rsp_valid && $past(!sb_we && (32'(sb_func) >= NUM_FUNCS))) |-> (sb_rsp_data == 32'hFFFF_FFFF));
endmodule

bind cfg_access_unit cfg_access_chk #(
  .FUNC_W(FUNC_W), .NODE_W(NODE_W), .NUM_FUNCS(NUM_FUNCS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lai_mode(lai_mode), .node_id(node_id),
  .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready),
  .lk_rsp_valid(lk_rsp_valid), .lk_rsp_ok(lk_rsp_ok), .lk_rsp_data(lk_rsp_data),
  .sb_req_valid(sb_req_valid), .sb_we(sb_we), .sb_node(sb_node), .sb_func(sb_func),
  .sb_rsp_valid(sb_rsp_valid), .sb_rsp_data(sb_rsp_data)
);

// File: tb/tb_cfg_access_unit.sv
`timescale 1ns/1ps
module tb_cfg_access_unit;
  localparam int NF  = 2;
  localparam int RPF = 8;
  localparam logic [6:0] MY_NODE = 7'h2A;

  logic clk = 0, rst_n = 0, lai_mode = 0;
  logic [6:0] node_id = MY_NODE;
  logic lk_req_valid = 0, lk_we = 0, lk_req_ready, lk_rsp_valid, lk_rsp_ok;
  logic [4:0] lk_dev = 0;
  logic [2:0] lk_func = 0;
  logic [7:0] lk_off = 0;
  logic [1:0] lk_size = 0;
  logic [31:0] lk_wdata = 0, lk_rsp_data;
  logic sb_req_valid = 0, sb_we = 0, sb_rsp_valid;
  logic [6:0] sb_node = 0;
  logic [2:0] sb_func = 0;
  logic [7:0] sb_off = 0;
  logic [1:0] sb_size = 0;
  logic [31:0] sb_wdata = 0, sb_rsp_data;

  always #4 clk = ~clk;

  cfg_access_unit #(.NUM_FUNCS(NF), .REGS_PER_FUNC(RPF)) dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] model [NF*RPF];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m_fits(input logic [7:0] o, input logic [1:0] sz);
    case (sz)
      2'd0: return 1'b1;
      2'd1: return o[1:0] != 2'd3;
      2'd2: return o[1:0] == 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_mapped(input logic [2:0] f, input logic [7:0] o, input logic [1:0] sz);
    return (int'(f) < NF) && (int'(o[7:2]) < RPF) && m_fits(o, sz);
  endfunction

  function automatic logic [31:0] m_rd(input logic [2:0] f, input logic [7:0] o, input logic [1:0] sz);
    logic [31:0] w;
    int nb;
    if (int'(f) >= NF) return 32'hFFFF_FFFF;
    if (!m_mapped(f, o, sz)) return 32'h0;
    w = model[int'(f)*RPF + int'(o[7:2])];
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    m_rd = 32'h0;
    for (int k = 0; k < nb; k++) m_rd[8*k +: 8] = w[8*(int'(o[1:0])+k) +: 8];
  endfunction

  task automatic m_wr(input logic [2:0] f, input logic [7:0] o, input logic [1:0] sz, input logic [31:0] d);
    int nb;
    if (!m_mapped(f, o, sz)) return;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int k = 0; k < nb; k++)
      model[int'(f)*RPF + int'(o[7:2])][8*(int'(o[1:0])+k) +: 8] = d[8*k +: 8];
  endtask

  task automatic sb_op(input logic we, input logic [6:0] nd, input logic [2:0] f, input logic [7:0] o,
                       input logic [1:0] sz, input logic [31:0] wd, output logic v, output logic [31:0] d);
    @(negedge clk);
    sb_req_valid = 1; sb_we = we; sb_node = nd; sb_func = f; sb_off = o; sb_size = sz; sb_wdata = wd;
    @(posedge clk); #1;
    v = sb_rsp_valid; d = sb_rsp_data;
    sb_req_valid = 0;
  endtask

  task automatic lk_op(input logic we, input logic [4:0] dv, input logic [2:0] f, input logic [7:0] o,
                       input logic [1:0] sz, input logic [31:0] wd, output logic v, output logic ok, output logic [31:0] d);
    @(negedge clk);
    lk_req_valid = 1; lk_we = we; lk_dev = dv; lk_func = f; lk_off = o; lk_size = sz; lk_wdata = wd;
    @(posedge clk); #1;
    v = lk_rsp_valid; ok = lk_rsp_ok; d = lk_rsp_data;
    lk_req_valid = 0;
  endtask

  task automatic sb_read_chk(input string tag, input logic [2:0] f, input logic [7:0] o, input logic [1:0] sz);
    logic v; logic [31:0] d;
    sb_op(0, MY_NODE, f, o, sz, 0, v, d);
    chk({tag, " valid"}, {31'b0, v}, 32'd1);
    chk(tag, d, m_rd(f, o, sz));
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic v, ok; logic [31:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < NF*RPF; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R10 reset state
    chk("R10 sb_rsp_valid", {31'b0, sb_rsp_valid}, 0);
    chk("R10 lk_rsp_valid", {31'b0, lk_rsp_valid}, 0);
    chk("R10 lk_req_ready", {31'b0, lk_req_ready}, 1);
    sb_read_chk("R10 reg zero", 3'd1, 8'h1C, 2'd2);

    // R1 sizes and byte order
    sb_op(1, MY_NODE, 0, 8'h04, 2'd2, 32'h4433_2211, v, d); m_wr(0, 8'h04, 2'd2, 32'h4433_2211);
    chk("R9 write rsp data", d, 0);
    sb_read_chk("R1 byte", 0, 8'h06, 2'd0);
    chk("R1 byte literal", m_rd(0, 8'h06, 2'd0), 32'h33);
    lk_op(0, 5'd0, 0, 8'h05, 2'd1, 0, v, ok, d);
    chk("R1 word lk", d, 32'h3322);
    sb_read_chk("R1 dword", 0, 8'h04, 2'd2);

    // R2 partial writes
    sb_op(1, MY_NODE, 0, 8'h07, 2'd0, 32'hAA, v, d); m_wr(0, 8'h07, 2'd0, 32'hAA);
    lk_op(0, 5'd3, 0, 8'h04, 2'd2, 0, v, ok, d);
    chk("R2 byte merge", d, 32'hAA33_2211);
    lk_op(1, 5'd3, 0, 8'h04, 2'd1, 32'hBEEF, v, ok, d); m_wr(0, 8'h04, 2'd1, 32'hBEEF);
    sb_read_chk("R2 word merge", 0, 8'h04, 2'd2);
    chk("R2 literal", m_rd(0, 8'h04, 2'd2), 32'hAA33_BEEF);

    // R3 device field ignored
    lk_op(1, 5'h1F, 1, 8'h00, 2'd2, 32'hCAFE_F00D, v, ok, d); m_wr(1, 8'h00, 2'd2, 32'hCAFE_F00D);
    chk("R3 valid dev1F", {31'b0, v}, 1);
    lk_op(0, 5'h11, 1, 8'h00, 2'd2, 0, v, ok, d);
    chk("R3 read dev11", d, 32'hCAFE_F00D);

    // R4 node filter
    sb_op(1, 7'h15, 0, 8'h08, 2'd2, 32'h1234_5678, v, d);
    chk("R4 no response", {31'b0, v}, 0);
    sb_read_chk("R4 no write", 0, 8'h08, 2'd2);

    // R5 debug mode
    @(negedge clk); lai_mode = 1;
    lk_op(1, 0, 0, 8'h08, 2'd2, 32'h5555_AAAA, v, ok, d);
    chk("R5 valid", {31'b0, v}, 1);
    chk("R5 ok low", {31'b0, ok}, 0);
    lk_op(0, 0, 0, 8'h04, 2'd2, 0, v, ok, d);
    chk("R5 read data zero", d, 0);
    chk("R5 read ok low", {31'b0, ok}, 0);
    sb_read_chk("R5 sb alive", 0, 8'h04, 2'd2);
    @(negedge clk); lai_mode = 0;
    lk_op(0, 0, 0, 8'h08, 2'd2, 0, v, ok, d);
    chk("R5 no write", d, m_rd(0, 8'h08, 2'd2));
    chk("R5 ok back", {31'b0, ok}, 1);

    // R6 unimplemented function
    sb_op(1, MY_NODE, 3'd5, 8'h00, 2'd2, 32'h0BAD_0BAD, v, d);
    sb_read_chk("R6 sb ones", 3'd5, 8'h00, 2'd2);
    lk_op(0, 0, 3'd7, 8'h10, 2'd0, 0, v, ok, d);
    chk("R6 lk ones", d, 32'hFFFF_FFFF);
    sb_read_chk("R6 no alias", 3'd1, 8'h00, 2'd2);

    // R7 unlisted offsets and misaligned accesses
    sb_op(1, MY_NODE, 0, 8'h40, 2'd2, 32'hDEAD_BEEF, v, d);
    sb_read_chk("R7 beyond map", 0, 8'h40, 2'd2);
    chk("R7 beyond literal", m_rd(0, 8'h40, 2'd2), 0);
    sb_op(1, MY_NODE, 0, 8'h07, 2'd1, 32'h7777, v, d);
    sb_read_chk("R7 word cross read", 0, 8'h07, 2'd1);
    sb_read_chk("R7 word cross no write", 0, 8'h04, 2'd2);
    sb_op(1, MY_NODE, 0, 8'h06, 2'd2, 32'h9999_9999, v, d);
    sb_read_chk("R7 dword misaligned no write", 0, 8'h04, 2'd2);
    sb_read_chk("R7 size3", 0, 8'h04, 2'd3);

    // R8 same-cycle arbitration
    @(negedge clk);
    sb_req_valid = 1; sb_we = 0; sb_node = MY_NODE; sb_func = 0; sb_off = 8'h04; sb_size = 2'd2;
    lk_req_valid = 1; lk_we = 0; lk_dev = 0; lk_func = 1; lk_off = 8'h00; lk_size = 2'd2;
    #1;
    chk("R8 lk held", {31'b0, lk_req_ready}, 0);
    @(posedge clk); #1;
    chk("R8 sb first", {31'b0, sb_rsp_valid}, 1);
    chk("R8 sb data", sb_rsp_data, m_rd(0, 8'h04, 2'd2));
    chk("R8 lk waits", {31'b0, lk_rsp_valid}, 0);
    sb_req_valid = 0;
    @(posedge clk); #1;
    chk("R8 lk next", {31'b0, lk_rsp_valid}, 1);
    chk("R8 lk data", lk_rsp_data, m_rd(1, 8'h00, 2'd2));
    lk_req_valid = 0;

    // R9 reads without side effects
    sb_read_chk("R9 reread a", 1, 8'h00, 2'd2);
    sb_read_chk("R9 reread b", 1, 8'h00, 2'd2);

    // Random mix
    for (int it = 0; it < 500; it++) begin
      logic we; logic [2:0] f; logic [7:0] o; logic [1:0] sz; logic [31:0] wd;
      we = $urandom_range(0, 1);
      f  = 3'($urandom_range(0, 2));
      o  = 8'($urandom_range(0, 8'h27));
      sz = 2'($urandom_range(0, 3));
      wd = $urandom;
      if ($urandom_range(0, 1) == 0) begin
        logic [6:0] nd;
        nd = ($urandom_range(0, 7) == 0) ? 7'($urandom_range(0, 127)) : MY_NODE;
        sb_op(we, nd, f, o, sz, wd, v, d);
        chk("R4 rnd sb valid", {31'b0, v}, {31'b0, nd == MY_NODE});
        if (nd == MY_NODE) begin
          chk("R1 rnd sb data", d, we ? 32'h0 : m_rd(f, o, sz));
          if (we) m_wr(f, o, sz, wd);
        end
      end else begin
        lk_op(we, 5'($urandom_range(0, 31)), f, o, sz, wd, v, ok, d);
        chk("R9 rnd lk valid", {31'b0, v}, 1);
        chk("R7 rnd lk data", d, we ? 32'h0 : m_rd(f, o, sz));
        if (we) m_wr(f, o, sz, wd);
      end
    end
    for (int r = 0; r < RPF; r++) sb_read_chk("R2 final sweep", 0, 8'(4*r), 2'd2);

    finish_run();
  end
endmodule